// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of a scratchpad built from independent, word-interleaved banks. A group of lanes presents one request together. Each lane has an active flag, a word address and, for writes, a data word. All active lanes share one direction, read or write. The block sorts the lanes by bank and serves the whole group in as few cycles as the bank conflicts allow. Lanes that name different words in the same bank go in separate cycles. Lanes that name the same word share one bank access, either as a read broadcast or as a merged write.

In every serving cycle the block drives a per-bank enable and row, and a per-lane grant mask. In the last serving cycle it raises a done strobe together with the number of cycles the request took. The bank storage is a set of simple synchronous RAMs inside the block. Read data for a granted lane comes back one cycle after its grant. A new request is accepted only while the block is idle.

Top module: `bkc_serializer`

## Requirements
- R1: The low log2(NUM_BANKS) bits of a lane's word address select its bank, and the remaining upper bits select the row inside that bank. An enabled bank drives that row on its slice of `bank_row` (bank b uses bits [b*ROW_W +: ROW_W]).
- R2: When every active lane addresses a different bank, all of them are granted in the first serving cycle, done rises in that same cycle, and `cycles` reads 1.
- R3: The number of serving cycles, reported on `cycles` while `done` is high, equals the largest number of distinct word addresses that active lanes request within any one bank. A stride-2 pattern over 8 lanes and 8 banks takes 2 cycles. Eight different words in one bank take 8 cycles.
- R4: Active lanes that request the identical word address are served together in one cycle. When all lanes name one address, the request completes in a single cycle.
- R5: In each serving cycle, every bank serves the word of its lowest-numbered still-pending lane, plus every other pending lane that names that same word. A lane is granted exactly once per request.
- R6: Inactive lanes are never granted. They do not enable a bank, add a cycle or change stored data. A request with no active lane finishes in its first cycle, with `cycles` reading 0 and no bank enabled.
- R7: A write stores each granted lane's data at its word. When several lanes write one word, the data of the highest-numbered such lane is kept.
- R8: On a read, `rsp_valid` for a lane rises in the cycle after that lane's grant, and `rsp_data` for that lane then holds the word stored at its address.
- R9: `req_ready` is high only while idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `done` marks the last serving cycle, and `req_ready` is high again in the following cycle.
- R10: After reset the block is idle: `req_ready` is high, and `grant`, `bank_en`, `done` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request group is presented |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 = write group, 0 = read group |
| req_active | input | NUM_LANES | Per-lane active flag |
| req_addr | input | NUM_LANES*ADDR_W | Per-lane word address, lane l at [l*ADDR_W +: ADDR_W] |
| req_wdata | input | NUM_LANES*DATA_W | Per-lane write data, lane l at [l*DATA_W +: DATA_W] |
| grant | output | NUM_LANES | Lanes served in the current cycle |
| bank_en | output | NUM_BANKS | Banks accessed in the current cycle |
| bank_row | output | NUM_BANKS*ROW_W | Row accessed in each bank |
| done | output | 1 | Last serving cycle of the request |
| cycles | output | CNT_W | Serving cycles of the request, valid with done |
| rsp_valid | output | NUM_LANES | Read data valid per lane |
| rsp_data | output | NUM_LANES*DATA_W | Read data per lane |

## Verification
The bench builds the block with 8 lanes, 8 banks, 6-bit word addresses and 16-bit data. With these values every bank has 8 rows, and one group can put all of its lanes into a single bank. That makes the worst case of 8 serialized cycles, stride conflicts, broadcasts and mixed groups reachable in a few dozen cycles each. It also makes it possible to fill the whole storage first, so every later read has a known expected word. Write collisions, with and without an inactive lane among the colliding lanes, are read back through the normal read path.

// File: rtl/bkc_pkg.sv
// Package: shared types for the banked conflict serializer.
// Assumes nothing beyond a two-state control flow (idle / serving).
package bkc_pkg;

    // Controller state: waiting for a group, or serving one
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bkc_state_e;

endpackage

// File: rtl/bkc_bank_pick.sv
// Module: per-bank lane picker.
// For one bank it finds the lowest-numbered pending lane that maps to this bank,
// takes that lane's word as the word served this cycle, and marks every pending
// lane naming the same word. It also selects the highest-numbered marked lane as
// the write-data source.
// Assumes NUM_BANKS is a power of two and ADDR_W > log2(NUM_BANKS).
module bkc_bank_pick #(
    parameter int NUM_LANES = 32,
    parameter int NUM_BANKS = 32,
    parameter int ADDR_W    = 10,
    parameter int BANK_ID   = 0,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = ADDR_W - BANK_W,
    localparam int LANE_W   = $clog2(NUM_LANES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LANES-1:0]        pending_i,
    input  logic [NUM_LANES*ADDR_W-1:0] addr_i,
    output logic                        en_o,
    output logic [ROW_W-1:0]            row_o,
    output logic [NUM_LANES-1:0]        serve_o,
    output logic [LANE_W-1:0]           wsel_o
);

    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

    logic [ADDR_W-1:0]    lane_addr [NUM_LANES];
    logic [NUM_LANES-1:0] hit;
    logic [ADDR_W-1:0]    lead_addr;
    logic                 found;

    // Unpack lane addresses and flag pending lanes mapped to this bank
    always_comb begin
        for (int l = 0; l < NUM_LANES; l++) begin
            lane_addr[l] = addr_i[l*ADDR_W +: ADDR_W];
            hit[l]       = pending_i[l] && (lane_addr[l][BANK_W-1:0] == MY_BANK);
        end
    end

    // Lowest-numbered hitting lane decides the word of this cycle
    always_comb begin
        found     = 1'b0;
        lead_addr = '0;
        for (int l = NUM_LANES - 1; l >= 0; l--) begin
            if (hit[l]) begin
                found     = 1'b1;
                lead_addr = lane_addr[l];
            end
        end
    end

    // Serve every hitting lane that names the leading word; last one supplies write data
    always_comb begin
        serve_o = '0;
        wsel_o  = '0;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (hit[l] && (lane_addr[l] == lead_addr)) begin
                serve_o[l] = 1'b1;
                wsel_o     = LANE_W'(l);
            end
        end
    end

    assign en_o  = found;
    assign row_o = lead_addr[ADDR_W-1:BANK_W];

    // An enabled bank always serves at least one lane
    assert_en_serves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> (serve_o != '0));

    // Only pending lanes can be served by this bank
    assert_serve_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (serve_o & ~pending_i) == '0);

    // The write-data source is itself a served lane
    assert_wsel_served_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> serve_o[wsel_o]);

endmodule

// File: rtl/bkc_bank_ram.sv
// Module: one scratchpad bank, single port, synchronous.
// A write stores the word at the row; a read returns the row's word on the
// next cycle. Storage is not reset; the read register is.
// Assumes at most one access per cycle (en_i).
module bkc_bank_ram #(
    parameter int ROW_W  = 5,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store write data at the addressed row
    always_ff @(posedge clk) begin
        if (en_i && we_i) begin
            mem[row_i] <= wdata_i;
        end
    end

    // Register the addressed row on a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (en_i && !we_i) begin
            rdata_o <= mem[row_i];
        end
    end

endmodule

// File: rtl/bkc_serializer.sv
// Module: banked scratchpad conflict serializer (top).
// Accepts one group of per-lane word requests while idle, then serves it over
// as many cycles as the worst bank conflict needs. Each cycle every bank takes
// the word of its lowest pending lane and all pending lanes sharing it.
// Read data returns one cycle after grant.
// Assumes NUM_BANKS is a power of two, NUM_LANES >= 2, ADDR_W > log2(NUM_BANKS).
module bkc_serializer #(
    parameter int NUM_LANES = 32,
    parameter int NUM_BANKS = 32,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = ADDR_W - BANK_W,
    localparam int LANE_W   = $clog2(NUM_LANES),
    localparam int CNT_W    = $clog2(NUM_LANES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [NUM_LANES-1:0]        req_active,
    input  logic [NUM_LANES*ADDR_W-1:0] req_addr,
    input  logic [NUM_LANES*DATA_W-1:0] req_wdata,
    output logic [NUM_LANES-1:0]        grant,
    output logic [NUM_BANKS-1:0]        bank_en,
    output logic [NUM_BANKS*ROW_W-1:0]  bank_row,
    output logic                        done,
    output logic [CNT_W-1:0]            cycles,
    output logic [NUM_LANES-1:0]        rsp_valid,
    output logic [NUM_LANES*DATA_W-1:0] rsp_data
);

    import bkc_pkg::*;

    bkc_state_e                  state_q;
    logic [NUM_LANES-1:0]        pend_q;
    logic                        we_q;
    logic [NUM_LANES*ADDR_W-1:0] addr_q;
    logic [NUM_LANES*DATA_W-1:0] wdata_q;
    logic [CNT_W-1:0]            cnt_q;
    logic [NUM_LANES-1:0]        rsp_q;

    logic [NUM_LANES-1:0]        serve [NUM_BANKS];
    logic [LANE_W-1:0]           wsel  [NUM_BANKS];
    logic [DATA_W-1:0]           rdata [NUM_BANKS];
    logic                        accept;
    logic                        running;
    logic [NUM_LANES-1:0]        left_after;

    assign running    = (state_q == ST_RUN);
    assign req_ready  = !running;
    assign accept     = req_valid && req_ready;
    assign left_after = pend_q & ~grant;
    assign done       = running && (left_after == '0);
    assign cycles     = done ? (cnt_q + {{(CNT_W-1){1'b0}}, |grant}) : '0;
    assign rsp_valid  = rsp_q;

    // Per-bank picker and storage
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [ROW_W-1:0] row_b;
        logic             en_b;

        bkc_bank_pick #(
            .NUM_LANES (NUM_LANES),
            .NUM_BANKS (NUM_BANKS),
            .ADDR_W    (ADDR_W),
            .BANK_ID   (b)
        ) u_pick (
            .clk       (clk),
            .rst_n     (rst_n),
            .pending_i (running ? pend_q : '0),
            .addr_i    (addr_q),
            .en_o      (en_b),
            .row_o     (row_b),
            .serve_o   (serve[b]),
            .wsel_o    (wsel[b])
        );

        bkc_bank_ram #(
            .ROW_W  (ROW_W),
            .DATA_W (DATA_W)
        ) u_ram (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_b),
            .we_i    (we_q),
            .row_i   (row_b),
            .wdata_i (wdata_q[wsel[b]*DATA_W +: DATA_W]),
            .rdata_o (rdata[b])
        );

        assign bank_en[b]                    = en_b;
        assign bank_row[b*ROW_W +: ROW_W]    = row_b;
    end

    // Per-lane read data routed from the lane's bank
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign rsp_data[l*DATA_W +: DATA_W] = rdata[addr_q[l*ADDR_W +: BANK_W]];
    end

    // Merge the per-bank served masks into the lane grant
    always_comb begin
        grant = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            grant = grant | serve[b];
        end
    end

    // Controller: accept a group, retire served lanes, return to idle when empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            cnt_q   <= '0;
        end else if (accept) begin
            state_q <= ST_RUN;
            pend_q  <= req_active;
            cnt_q   <= '0;
        end else if (running) begin
            pend_q <= left_after;
            if (grant != '0) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (done) begin
                state_q <= ST_IDLE;
            end
        end
    end

    // Latch the group's direction, addresses and data on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Remember which lanes were granted a read, for the response cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= (running && !we_q) ? grant : '0;
        end
    end

    // Granted lanes are always pending lanes
    assert_grant_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pend_q) == '0);

    // A serving cycle with lanes left always makes progress
    assert_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pend_q != '0) |-> (grant != '0));

    // Served lanes never come back as pending within a request
    assert_no_repend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ((pend_q & ~$past(pend_q)) == '0));

    // Done hands the block back to idle on the next cycle
    assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    // Cycle count can never exceed the lane count
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NUM_LANES));

    // Nothing is granted while idle
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (grant == '0 && bank_en == '0));

endmodule

// File: tb/sim_bkc_serializer.sv
// Bench: behavioural reference model of the serializer, compared every cycle.
module sim_bkc_serializer;

    localparam int  L      = 8;
    localparam int  B      = 8;
    localparam int  A      = 6;
    localparam int  D      = 16;
    localparam int  RW     = 3;
    localparam int  CW     = 4;
    localparam int  WORDS  = 64;
    localparam time CLK_PERIOD = 10ns;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic           req_write = 1'b0;
    logic [L-1:0]   req_active = '0;
    logic [L*A-1:0] req_addr = '0;
    logic [L*D-1:0] req_wdata = '0;
    logic [L-1:0]   grant;
    logic [B-1:0]   bank_en;
    logic [B*RW-1:0] bank_row;
    logic           done;
    logic [CW-1:0]  cycles;
    logic [L-1:0]   rsp_valid;
    logic [L*D-1:0] rsp_data;

    int total = 0;
    int bad   = 0;

    int       t_addr [L];
    int       t_data [L];
    logic [L-1:0] t_act;
    logic     t_we;
    logic [D-1:0] mem_m [WORDS];
    string    rsp_tag = "R8";

    always #(CLK_PERIOD/2) clk = ~clk;

    bkc_serializer #(
        .NUM_LANES (L),
        .NUM_BANKS (B),
        .ADDR_W    (A),
        .DATA_W    (D)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_active (req_active),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .grant      (grant),
        .bank_en    (bank_en),
        .bank_row   (bank_row),
        .done       (done),
        .cycles     (cycles),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare read responses against the expected lanes and stored words
    task automatic check_rsp(input logic [L-1:0] exp_rd);
        chk(rsp_valid == exp_rd, rsp_tag, "rsp_valid", rsp_valid, exp_rd);
        for (int l = 0; l < L; l++) begin
            if (exp_rd[l]) begin
                chk(rsp_data[l*D +: D] == mem_m[t_addr[l]], rsp_tag, "rsp_data",
                    rsp_data[l*D +: D], mem_m[t_addr[l]]);
            end
        end
    endtask

    // Issue the group held in t_* and follow it cycle by cycle
    task automatic run_req(input string cyc_tag);
        int           exp_cyc;
        int           steps;
        logic [L-1:0] pend;
        logic [L-1:0] prev_rd;
        logic [L-1:0] eg;
        logic [B-1:0] een;
        int           erow [B];
        bit           edone;

        // expected cycle count: worst count of distinct words within a bank
        exp_cyc = 0;
        for (int b = 0; b < B; b++) begin
            int n = 0;
            for (int l = 0; l < L; l++) begin
                bit seen = 0;
                if (t_act[l] && (t_addr[l] % B) == b) begin
                    for (int k = 0; k < l; k++)
                        if (t_act[k] && t_addr[k] == t_addr[l]) seen = 1;
                    if (!seen) n++;
                end
            end
            if (n > exp_cyc) exp_cyc = n;
        end

        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready idle", req_ready, 1);
        req_valid  = 1'b1;
        req_write  = t_we;
        req_active = t_act;
        for (int l = 0; l < L; l++) begin
            req_addr[l*A +: A]  = A'(t_addr[l]);
            req_wdata[l*D +: D] = D'(t_data[l]);
        end
        @(negedge clk);
        req_valid = 1'b0;

        pend    = t_act;
        prev_rd = '0;
        steps   = 0;
        forever begin
            check_rsp(prev_rd);
            chk(req_ready == 1'b0, "R9", "ready busy", req_ready, 0);
            eg  = '0;
            een = '0;
            for (int b = 0; b < B; b++) begin
                int first = -1;
                erow[b] = 0;
                for (int l = 0; l < L; l++)
                    if (first < 0 && pend[l] && (t_addr[l] % B) == b) first = l;
                if (first >= 0) begin
                    een[b]  = 1'b1;
                    erow[b] = t_addr[first] / B;
                    for (int l = 0; l < L; l++)
                        if (pend[l] && t_addr[l] == t_addr[first]) eg[l] = 1'b1;
                end
            end
            steps = steps + ((eg != '0) ? 1 : 0);
            chk(grant == eg, "R5", "grant", grant, eg);
            chk(bank_en == een, "R1", "bank_en", bank_en, een);
            for (int b = 0; b < B; b++)
                if (een[b])
                    chk(bank_row[b*RW +: RW] == RW'(erow[b]), "R1", "bank_row",
                        bank_row[b*RW +: RW], erow[b]);
            edone = ((pend & ~eg) == '0);
            chk(done == edone, "R9", "done", done, edone);
            if (edone) begin
                chk(int'(cycles) == exp_cyc, cyc_tag, "cycles", cycles, exp_cyc);
                chk(steps == exp_cyc, cyc_tag, "serving steps", steps, exp_cyc);
            end
            prev_rd = t_we ? '0 : eg;
            pend    = pend & ~eg;
            if (edone) break;
            @(negedge clk);
        end
        @(negedge clk);
        check_rsp(prev_rd);
        chk(req_ready == 1'b1, "R9", "ready after done", req_ready, 1);

        // stored result of a write: later lanes overwrite earlier ones
        if (t_we)
            for (int l = 0; l < L; l++)
                if (t_act[l]) mem_m[t_addr[l]] = D'(t_data[l]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready", req_ready, 1);
        chk(grant == '0, "R10", "grant", grant, 0);
        chk(bank_en == '0, "R10", "bank_en", bank_en, 0);
        chk(done == 1'b0, "R10", "done", done, 0);
        chk(rsp_valid == '0, "R10", "rsp_valid", rsp_valid, 0);

        // R2: fill every word, each group spread across all banks
        t_we  = 1'b1;
        t_act = '1;
        for (int k = 0; k < 8; k++) begin
            for (int l = 0; l < L; l++) begin
                t_addr[l] = k * 8 + l;
                t_data[l] = ((k * 8 + l) * 37 + 5) & 16'hffff;
            end
            run_req("R2");
        end

        // R2: read with a permuted, conflict-free bank pattern
        t_we = 1'b0;
        for (int l = 0; l < L; l++) t_addr[l] = ((3 * l) % 8) + 8 * ((l + 2) % 8);
        run_req("R2");

        // R3: stride-2 words, two lanes per used bank
        for (int l = 0; l < L; l++) t_addr[l] = 2 * l;
        run_req("R3");

        // R3: all lanes in one bank, all different words
        for (int l = 0; l < L; l++) t_addr[l] = 8 * l + 3;
        run_req("R3");

        // R4: every lane names one word
        for (int l = 0; l < L; l++) t_addr[l] = 13;
        run_req("R4");

        // R5: mixed duplicates and conflicts
        t_addr = '{1, 9, 1, 17, 2, 9, 10, 1};
        run_req("R5");

        // R6: inactive lanes in a single-bank group add no cycles
        for (int l = 0; l < L; l++) t_addr[l] = 8 * l + 3;
        t_act = 8'b0101_0101;
        run_req("R6");

        // R6: empty group
        t_act = '0;
        run_req("R6");

        // R7: all lanes write one word, then broadcast read it back
        t_we  = 1'b1;
        t_act = '1;
        for (int l = 0; l < L; l++) begin
            t_addr[l] = 20;
            t_data[l] = 16'h1100 + l;
        end
        run_req("R7");
        t_we    = 1'b0;
        rsp_tag = "R7";
        run_req("R4");

        // R7 with R6: inactive highest lane must not win the collision
        t_we  = 1'b1;
        t_act = 8'b0111_1111;
        for (int l = 0; l < L; l++) begin
            t_addr[l] = (l < 4) ? 21 : 29;
            t_data[l] = 16'h2200 + 16 * l;
        end
        run_req("R7");
        t_we  = 1'b0;
        t_act = '1;
        run_req("R3");
        rsp_tag = "R8";

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule